// File: doc/BRIEF.md
# PLL-Side System Clock Enable Divider

This block turns one fast source clock into three synchronous clock enables: a core enable, a bus enable and a peripheral enable. Each enable is a single-cycle pulse that marks one period of the divided clock, so downstream logic runs on the fast clock and qualifies its registers with the matching enable. The peripheral enable is not divided from the source directly. It counts bus enables, so its ratio to the source is the product of the bus and peripheral divisors.

The ratios come from a 32-bit configuration word. Three code fields pick each divisor from a fixed table, and a not-bypass flag picks the source. When the flag is clear, the dividers advance only on cycles marked by the crystal tick input, so the divided clocks follow the crystal reference. When the flag is set, the dividers advance on every cycle of the fast clock. The word is loaded while reset is held. At run time a new word can be written with a strobe. The new word is held and takes effect only at a common terminal point, where all three dividers end a period together, so no divided clock is ever cut short. The divisor each enable is currently using is reported on dedicated outputs.

Top module: `sysclk_divider`

## Requirements
- R1: The core divisor comes from bits 27:25 of the word. Codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16, and codes 5, 6 and 7 give 1. It is reported on `core_div`.
- R2: The bus divisor comes from bits 22:20. Codes 0 to 7 give, in code order, 1, 2, 4, 5, 6, 8, 16 and 32. It is reported on `bus_div`.
- R3: The peripheral divisor comes from bits 19:18. Codes 0 to 3 give 1, 2, 4 and 8, and the value is reported on `per_div`. `per_en` pulses once every `bus_div*per_div` source ticks because it counts bus enables.
- R4: `per_en` is never high in a cycle where `bus_en` is low.
- R5: With divisor N, `core_en` and `bus_en` are each high on the Nth source tick of every run of N source ticks and low otherwise. A divisor of 1 keeps the enable high on every source tick.
- R6: Bit 23 is the not-bypass flag. When it is 0, `src_en` equals `xtal_tick`. When it is 1, `src_en` is 1 on every cycle. No enable is high in a cycle where `src_en` is low.
- R7: While `rst_n` is low, the word on `cfg_word` is loaded every cycle and its divisors are reported. After release, all dividers start from the beginning of a period, so the first enable of divisor N falls on the Nth source tick.
- R8: A word written with `cfg_wr` is held pending. Divisors and enable timing keep the old word until a cycle in which `core_en` and `per_en` are both high (the common terminal point). The pending word applies from the next cycle.
- R9: A write that arrives in the same cycle as a common terminal point does not apply at that point. It waits for the following common terminal point. If an earlier write was already pending, that earlier word is the one applied at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock (PLL side) |
| rst_n | input | 1 | Synchronous active-low reset; the configuration word is loaded while it is low |
| xtal_tick | input | 1 | Marks the fast-clock cycles that correspond to crystal reference edges |
| cfg_wr | input | 1 | Strobe that captures `cfg_word` as the pending configuration |
| cfg_word | input | 32 | Configuration word (divider codes and not-bypass flag) |
| src_en | output | 1 | Source tick that advances the dividers |
| core_en | output | 1 | Core clock enable pulse |
| bus_en | output | 1 | Bus clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse (derived from bus enables) |
| core_div | output | 5 | Core divisor in use |
| bus_div | output | 6 | Bus divisor in use |
| per_div | output | 4 | Peripheral divisor in use, counted in bus periods |

## Verification
Two events can fall in the same cycle: a configuration write and the commit at a common terminal point. The bench reproduces this on purpose. Before each cycle its reference model predicts whether that cycle will be a terminal point, and it raises `cfg_wr` exactly then. The result is judged at the ports. The divisors reported on the following cycle must still be the old ones, and the enable stream must keep the old timing until the next terminal point, where the new word appears. A scoreboard compares every cycle against a model that counts source ticks and divides them modulo each ratio, rather than keeping one counter per divider.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int CFG_W    = 32;
  localparam int CORE_LSB = 25;
  localparam int BUS_LSB  = 20;
  localparam int PER_LSB  = 18;
  localparam int NBYP_BIT = 23;
  localparam int CORE_CW  = 3;
  localparam int BUS_CW   = 3;
  localparam int PER_CW   = 2;
  localparam int CORE_DW  = 5;
  localparam int BUS_DW   = 6;
  localparam int PER_DW   = 4;

  // Core: powers of two up to code 4, every other code is divide-by-one
  function automatic logic [CORE_DW-1:0] core_ratio(input logic [CORE_CW-1:0] code);
    logic [CORE_DW-1:0] r;
    if (code <= CORE_CW'(4)) r = CORE_DW'(1) << code;
    else                     r = CORE_DW'(1);
    return r;
  endfunction

  // Bus: non-power-of-two steps 5 and 6 sit in the middle of the table
  function automatic logic [BUS_DW-1:0] bus_ratio(input logic [BUS_CW-1:0] code);
    logic [BUS_DW-1:0] r;
    case (code)
      3'd3:    r = BUS_DW'(5);
      3'd4:    r = BUS_DW'(6);
      3'd5:    r = BUS_DW'(8);
      3'd6:    r = BUS_DW'(16);
      3'd7:    r = BUS_DW'(32);
      default: r = BUS_DW'(1) << code;
    endcase
    return r;
  endfunction

  function automatic logic [PER_DW-1:0] per_ratio(input logic [PER_CW-1:0] code);
    return PER_DW'(1) << code;
  endfunction
endpackage

// File: rtl/sysclk_div_stage.sv
module sysclk_div_stage #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;
  logic         at_last;

  assign at_last = (cnt == (ratio - ONE));
  assign tick    = adv & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (adv)  cnt <= at_last ? '0 : cnt + ONE;
  end
endmodule

// File: rtl/sysclk_cfg_regs.sv
module sysclk_cfg_regs #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [CW-1:0] cfg_word,
  input  logic          commit,
  output logic [CW-1:0] active,
  output logic          pending
);
  logic [CW-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= cfg_word;
      shadow  <= cfg_word;
      pending <= 1'b0;
    end else begin
      // Only a word held since an earlier cycle may commit
      if (commit && pending) active <= shadow;
      if (cfg_wr) begin
        shadow  <= cfg_word;
        pending <= 1'b1;
      end else if (commit) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xtal_tick,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_word,
  output logic               src_en,
  output logic               core_en,
  output logic               bus_en,
  output logic               per_en,
  output logic [CORE_DW-1:0] core_div,
  output logic [BUS_DW-1:0]  bus_div,
  output logic [PER_DW-1:0]  per_div
);
  logic [CFG_W-1:0] active_cfg;
  logic             cfg_pending;
  logic             common_term;

  sysclk_cfg_regs #(.CW(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_word (cfg_word),
    .commit   (common_term),
    .active   (active_cfg),
    .pending  (cfg_pending)
  );

  assign src_en   = active_cfg[NBYP_BIT] ? 1'b1 : xtal_tick;
  assign core_div = core_ratio(active_cfg[CORE_LSB +: CORE_CW]);
  assign bus_div  = bus_ratio(active_cfg[BUS_LSB +: BUS_CW]);
  assign per_div  = per_ratio(active_cfg[PER_LSB +: PER_CW]);

  sysclk_div_stage #(.W(CORE_DW)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(src_en), .ratio(core_div), .tick(core_en)
  );

  sysclk_div_stage #(.W(BUS_DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .adv(src_en), .ratio(bus_div), .tick(bus_en)
  );

  // Peripheral stage cascades off the bus enable
  sysclk_div_stage #(.W(PER_DW)) u_per (
    .clk(clk), .rst_n(rst_n), .adv(bus_en), .ratio(per_div), .tick(per_en)
  );

  // per_en implies bus_en, so this is the point where all three periods end
  assign common_term = core_en & per_en;
endmodule

// File: rtl/sysclk_divider_chk.sv
module sysclk_divider_chk
  import sysclk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               src_en,
  input logic               core_en,
  input logic               bus_en,
  input logic               per_en,
  input logic               common_term,
  input logic [CORE_DW-1:0] core_div,
  input logic [BUS_DW-1:0]  bus_div,
  input logic [PER_DW-1:0]  per_div
);
  p_per_needs_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> bus_en);

  p_en_needs_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en || bus_en || per_en) |-> src_en);

  p_unit_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && core_div == CORE_DW'(1)) |-> core_en);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && core_div != CORE_DW'(1) && !common_term) |=> !core_en);

  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !common_term |=> $stable({core_div, bus_div, per_div}));
endmodule

bind sysclk_divider sysclk_divider_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_en      (src_en),
  .core_en     (core_en),
  .bus_en      (bus_en),
  .per_en      (per_en),
  .common_term (common_term),
  .core_div    (core_div),
  .bus_div     (bus_div),
  .per_div     (per_div)
);

// File: tb/tb_sysclk_divider.sv
module tb_sysclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        src_en, core_en, bus_en, per_en;
  logic [4:0]  core_div;
  logic [5:0]  bus_div;
  logic [3:0]  per_div;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysclk_divider dut (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .cfg_wr(cfg_wr),
    .cfg_word(cfg_word), .src_en(src_en), .core_en(core_en), .bus_en(bus_en),
    .per_en(per_en), .core_div(core_div), .bus_div(bus_div), .per_div(per_div)
  );

  typedef struct {
    bit s, c, b, p;
    int cd, bd, pd;
  } item_t;
  item_t q[$];

  // Reference model state: ticks counted since the last common terminal point
  logic [31:0] m_act, m_shadow;
  bit          m_pend;
  int          m_k;

  function automatic int ref_core(int code);
    return (code > 4) ? 1 : (1 << code);
  endfunction
  function automatic int ref_bus(int code);
    int tbl[8] = '{1, 2, 4, 5, 6, 8, 16, 32};
    return tbl[code];
  endfunction
  function automatic int ref_per(int code);
    return 1 << code;
  endfunction
  function automatic logic [31:0] mk(int c, int b, int p, bit nbyp);
    return (32'(c) << 25) | (32'(b) << 20) | (32'(p) << 18) | (32'(nbyp) << 23);
  endfunction

  function automatic item_t model_eval(bit xt);
    item_t it;
    int kk;
    it.cd = ref_core(int'(m_act[27:25]));
    it.bd = ref_bus(int'(m_act[22:20]));
    it.pd = ref_per(int'(m_act[19:18]));
    it.s  = m_act[23] ? 1'b1 : xt;
    kk    = m_k + (it.s ? 1 : 0);
    it.c  = it.s && (kk % it.cd == 0);
    it.b  = it.s && (kk % it.bd == 0);
    it.p  = it.s && (kk % (it.bd * it.pd) == 0);
    return it;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: called at posedge+1, drives this cycle and pushes its expectation
  task automatic step(bit xt, bit wr, logic [31:0] w);
    item_t it;
    bit term;
    xtal_tick = xt; cfg_wr = wr; cfg_word = w;
    it = model_eval(xt);
    q.push_back(it);
    term = it.c && it.p;
    if (it.s) m_k++;
    if (term) m_k = 0;
    if (term && m_pend) m_act = m_shadow;
    if (wr) begin m_shadow = w; m_pend = 1; end
    else if (term) m_pend = 0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset(logic [31:0] w);
    rst_n = 1'b0; cfg_word = w; cfg_wr = 1'b0; xtal_tick = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    // R7: word loaded while reset is held
    check(int'(core_div) == ref_core(int'(w[27:25])), "R7/R1 core_div in reset", int'(core_div), ref_core(int'(w[27:25])));
    check(int'(bus_div) == ref_bus(int'(w[22:20])), "R7/R2 bus_div in reset", int'(bus_div), ref_bus(int'(w[22:20])));
    check(int'(per_div) == ref_per(int'(w[19:18])), "R7/R3 per_div in reset", int'(per_div), ref_per(int'(w[19:18])));
    rst_n = 1'b1;
    m_act = w; m_shadow = w; m_pend = 0; m_k = 0;
  endtask

  // Monitor: pops one expectation per cycle, away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      check(src_en == e.s, "R6 src_en", int'(src_en), int'(e.s));
      check(core_en == e.c, "R5 core_en", int'(core_en), int'(e.c));
      check(bus_en == e.b, "R5 bus_en", int'(bus_en), int'(e.b));
      check(per_en == e.p, "R3 per_en", int'(per_en), int'(e.p));
      check(!per_en || bus_en, "R4 per_en without bus_en", int'(bus_en), 1);
      check(int'(core_div) == e.cd, "R8 core_div", int'(core_div), e.cd);
      check(int'(bus_div) == e.bd, "R8 bus_div", int'(bus_div), e.bd);
      check(int'(per_div) == e.pd, "R8 per_div", int'(per_div), e.pd);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb, wc, wd;
    int old_cd;
    wa = mk(2, 3, 1, 1'b1);
    wb = mk(0, 4, 3, 1'b1);
    wc = mk(1, 0, 2, 1'b0);
    wd = mk(3, 1, 1, 1'b1);

    do_reset(wa);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, '0);

    // R8: mid-run write waits for the common terminal point
    step(1'b1, 1'b1, wb);
    for (int i = 0; i < 120; i++) step(1'b1, 1'b0, '0);

    // R6: crystal bypass, dividers advance on every third cycle only
    step(1'b1, 1'b1, wc);
    for (int i = 0; i < 150; i++) step((i % 3) == 0, 1'b0, '0);

    // R9: write lands exactly on a common terminal point
    for (int i = 0; i < 400; i++) begin
      item_t pr;
      pr = model_eval(1'b1);
      if (pr.c && pr.p) begin
        old_cd = pr.cd;
        step(1'b1, 1'b1, wd);
        check(int'(core_div) == old_cd, "R9 write on terminal deferred", int'(core_div), old_cd);
        break;
      end
      step(1'b1, 1'b0, '0);
    end
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, '0);
    check(int'(core_div) == 8, "R9 deferred word applied", int'(core_div), 8);

    // R1 R2 R3: every code of every field, through reset load
    for (int c = 0; c < 8; c++) begin
      do_reset(mk(c, c, c % 4, 1'b1));
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, '0);
    end

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule